// File: doc/BRIEF.md
# Phase-Offset Capture and Slew Corrector

This block sits between the selected reference and the phase detector of a PLL. It hands the loop a virtual reference edge in place of the raw one. When the reference selection changes, the block measures how many system-clock counts separate the reference edge from the following feedback edge. It stores that count and delays every later reference edge by it, so the loop sees no phase step. A return from holdover can trigger the same measurement when an enable input permits it.

An active-low clear input, synchronized inside the block, starts removal of the stored offset. During removal the offset moves one count at a time, at a fixed rate set by a divider parameter. It always takes the shorter way around the reference period, so the output drifts back into alignment with the reference. While clear stays low, no new offset is captured and the virtual edge coincides with the reference edge.

Time is counted in system clocks. The reference period in counts and the slew divider are parameters. The defaults match a 20 MHz clock, an 8 kHz reference and a limit of 61 µs of phase per second.

Top module: `phaseSlewCorrector`

## Requirements
- R1: A change of `refSel` arms a capture. The next `fbEdge` pulse then loads `phaseOffset` with the number of clocks since the most recent `refEdge` pulse. The value is 0 when both pulses fall in the same cycle.
- R2: A falling `holdover` arms a capture only while `holdRecoverEn` is 1. With `holdRecoverEn` at 0, leaving holdover leaves `phaseOffset` unchanged.
- R3: Outside a capture or a removal, `phaseOffset` holds its value. Feedback pulses with no armed capture do not change it. It always stays below PERIOD.
- R4: `virtEdge` pulses exactly `phaseOffset` clocks after a `refEdge` pulse. When the offset is 0, it pulses in the same cycle as `refEdge`.
- R5: `clrN` is sampled through a two-flop synchronizer. A low level seen at any clock edge starts removal. Removal continues after `clrN` returns high and ends with `phaseOffset` at 0.
- R6: During removal, `phaseOffset` changes by exactly one count every SLEW_DIV clocks. The first step comes SLEW_DIV clocks after removal starts.
- R7: An offset of at most PERIOD/2 is decremented. A larger offset is incremented, and it wraps from PERIOD-1 to 0.
- R8: While the synchronized clear is low, armed captures are dropped and feedback pulses capture nothing. Once the offset reaches 0 it stays there, and `virtEdge` follows `refEdge` with no delay.
- R9: After reset, `phaseOffset` is 0 and no capture is armed.
- R10: A capture completed after `clrN` has returned high ends any removal in progress. The new offset is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refSel | input | SEL_W | Index of the selected reference; any change triggers a capture |
| holdover | input | 1 | High while the loop is in holdover |
| holdRecoverEn | input | 1 | Allows a capture when holdover ends |
| clrN | input | 1 | Asynchronous active-low request to remove the offset |
| refEdge | input | 1 | One-cycle pulse per selected reference edge |
| fbEdge | input | 1 | One-cycle pulse per feedback edge |
| virtEdge | output | 1 | Virtual reference edge pulse |
| phaseOffset | output | OFS_W | Stored offset in clocks, modulo PERIOD |

## Verification
On every cycle, the assertions check the following:
- the offset stays inside the period;
- it holds whenever no capture or slew strobe fires;
- slew steps never come on consecutive cycles;
- each step moves in the direction the half-period rule gives;
- a zero offset stays zero while clear is low.

Only the bench's scenarios can show the rest:
- the captured value matching the spacing of reference and feedback pulses;
- the exact virtual-edge delay;
- the number of steps after a given wait;
- the gating of holdover recovery by its enable;
- a capture ending a removal.

// File: rtl/phaseSlewPkg.sv
package phaseSlewPkg;
  typedef struct packed {
    logic capture;   // load offset from the since-reference counter
    logic slewStep;  // move offset one count toward zero
  } corrStrobe_t;
endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ofsCtrl.sv
module ofsCtrl
  import phaseSlewPkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int SLEW_DIV = 16393
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrReq,
  input  logic [SEL_W-1:0] refSel,
  input  logic             holdover,
  input  logic             holdRecoverEn,
  input  logic             fbEdge,
  input  logic             offZero,
  output corrStrobe_t      strb
);
  localparam int DIV_W = (SLEW_DIV > 2) ? $clog2(SLEW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLEW_DIV - 1);

  logic [SEL_W-1:0] prevSel;
  logic             prevHold;
  logic             armed;
  logic             slewing;
  logic [DIV_W-1:0] presc;
  logic             trigger;

  assign trigger = (refSel != prevSel) || (prevHold && !holdover && holdRecoverEn);

  always_comb begin
    strb.capture  = armed && fbEdge && !clrReq;
    strb.slewStep = slewing && (presc == DIV_LAST) && !offZero && !strb.capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel  <= '0;
      prevHold <= 1'b0;
      armed    <= 1'b0;
      slewing  <= 1'b0;
      presc    <= '0;
    end else begin
      prevSel  <= refSel;
      prevHold <= holdover;

      if (clrReq)            armed <= 1'b0;
      else if (trigger)      armed <= 1'b1;
      else if (strb.capture) armed <= 1'b0;

      if (clrReq)                  slewing <= 1'b1;
      else if (strb.capture)       slewing <= 1'b0;
      else if (slewing && offZero) slewing <= 1'b0;

      if (!slewing)              presc <= '0;
      else if (presc == DIV_LAST) presc <= '0;
      else                        presc <= presc + 1'b1;
    end
  end

  // R6: slew steps are spaced by the divider, never back to back
  p_step_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.slewStep |=> !strb.slewStep);
endmodule

// File: rtl/ofsDatapath.sv
module ofsDatapath
  import phaseSlewPkg::*;
#(
  parameter int PERIOD = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEdge,
  input  logic              fbEdge,
  input  corrStrobe_t       strb,
  output logic              virtEdge,
  output logic              offZero,
  output logic [OFS_W-1:0]  offset
);
  localparam int OFS_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [OFS_W-1:0] LAST = OFS_W'(PERIOD - 1);
  localparam logic [OFS_W-1:0] HALF = OFS_W'(PERIOD / 2);
  localparam logic [OFS_W:0]   LIM  = (OFS_W+1)'(PERIOD);

  logic [OFS_W-1:0] sinceRef;
  logic [OFS_W-1:0] offsetQ;
  logic [OFS_W-1:0] dly;
  logic             pending;

  assign offZero  = (offsetQ == '0);
  assign offset   = offsetQ;
  assign virtEdge = (refEdge && offZero) || (pending && dly == OFS_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRef <= '0;
      offsetQ  <= '0;
      dly      <= '0;
      pending  <= 1'b0;
    end else begin
      if (refEdge)              sinceRef <= OFS_W'(1);
      else if (sinceRef == LAST) sinceRef <= '0;
      else                       sinceRef <= sinceRef + 1'b1;

      if (strb.capture) begin
        offsetQ <= refEdge ? '0 : sinceRef;
      end else if (strb.slewStep && !offZero) begin
        if (offsetQ <= HALF)      offsetQ <= offsetQ - 1'b1;
        else if (offsetQ == LAST) offsetQ <= '0;
        else                      offsetQ <= offsetQ + 1'b1;
      end

      if (refEdge) begin
        dly     <= offsetQ;
        pending <= !offZero;
      end else if (pending) begin
        dly <= dly - 1'b1;
        if (dly == OFS_W'(1)) pending <= 1'b0;
      end
    end
  end

  // R3: offset never leaves the period
  p_offset_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, offsetQ} < LIM);
  // R7: low half steps down
  p_dir_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slewStep && !offZero && offsetQ <= HALF) |=> offsetQ < $past(offsetQ));
  // R7: high half steps up or wraps to zero
  p_dir_up_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slewStep && offsetQ > HALF) |=> (offsetQ > $past(offsetQ) || offsetQ == '0));
endmodule

// File: rtl/phaseSlewCorrector.sv
module phaseSlewCorrector
  import phaseSlewPkg::*;
#(
  parameter int PERIOD      = 2500,
  parameter int SLEW_DIV    = 16393,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int OFS_W      = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] refSel,
  input  logic             holdover,
  input  logic             holdRecoverEn,
  input  logic             clrN,
  input  logic             refEdge,
  input  logic             fbEdge,
  output logic             virtEdge,
  output logic [OFS_W-1:0] phaseOffset
);
  corrStrobe_t strb;
  logic        clrSync;
  logic        clrReq;
  logic        offZero;

  bitSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clrSync (
    .clk(clk), .rstN(rstN), .din(clrN), .dout(clrSync)
  );
  assign clrReq = !clrSync;

  ofsCtrl #(.SEL_W(SEL_W), .SLEW_DIV(SLEW_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .refSel(refSel),
    .holdover(holdover), .holdRecoverEn(holdRecoverEn), .fbEdge(fbEdge),
    .offZero(offZero), .strb(strb)
  );

  ofsDatapath #(.PERIOD(PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .fbEdge(fbEdge), .strb(strb),
    .virtEdge(virtEdge), .offZero(offZero), .offset(phaseOffset)
  );

  // R3: with no strobe from control the datapath offset is frozen
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.slewStep) |=> $stable(phaseOffset));
  // R8: a zero offset stays zero while clear is requested
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && phaseOffset == '0) |=> phaseOffset == '0);
endmodule

// File: tb/phaseSlewCorrector_bench.sv
module phaseSlewCorrector_bench;
  localparam int PERIOD = 40;
  localparam int DIV    = 16;
  localparam int OW     = $clog2(PERIOD);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    refSel = '0;
  logic          holdover = 1'b0;
  logic          holdRecoverEn = 1'b0;
  logic          clrN = 1'b1;
  logic          refEdge = 1'b0;
  logic          fbEdge = 1'b0;
  logic          virtEdge;
  logic [OW-1:0] phaseOffset;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phaseSlewCorrector #(.PERIOD(PERIOD), .SLEW_DIV(DIV), .SEL_W(2)) u_phaseSlewCorrector (
    .clk(clk), .rstN(rstN), .refSel(refSel), .holdover(holdover),
    .holdRecoverEn(holdRecoverEn), .clrN(clrN), .refEdge(refEdge),
    .fbEdge(fbEdge), .virtEdge(virtEdge), .phaseOffset(phaseOffset)
  );

  function automatic int slewModel(int start, int steps);
    int v = start;
    for (int i = 0; i < steps; i++) begin
      if (v == 0) v = 0;
      else if (v <= PERIOD/2) v = v - 1;
      else v = (v == PERIOD-1) ? 0 : v + 1;
    end
    return v;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOfs(string req, int exp);
    check(int'(phaseOffset) == exp, req, int'(phaseOffset), exp);
  endtask

  task automatic trig();
    @(negedge clk);
    refSel = refSel + 2'd1;
    tick(3);
  endtask

  task automatic capturePair(int d);
    @(negedge clk);
    refEdge = 1'b1;
    fbEdge  = (d == 0);
    @(negedge clk);
    refEdge = 1'b0;
    fbEdge  = 1'b0;
    if (d > 0) begin
      repeat (d-1) @(negedge clk);
      fbEdge = 1'b1;
      @(negedge clk);
      fbEdge = 1'b0;
    end
    tick(2);
  endtask

  task automatic measureVirt(output int lat);
    lat = -1;
    @(negedge clk);
    refEdge = 1'b1;
    #1;
    if (virtEdge) lat = 0;
    @(negedge clk);
    refEdge = 1'b0;
    for (int j = 1; j <= PERIOD + 2; j++) begin
      #1;
      if (lat < 0 && virtEdge) lat = j;
      @(negedge clk);
    end
    tick(2);
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clrN = 1'b0;
    tick(2);
    clrN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int d;
    void'($urandom(32'd20240611));
    tick(5);
    rstN = 1'b1;
    tick(2);

    // R9: reset state
    checkOfs("R9 reset offset", 0);
    measureVirt(lat);
    check(lat == 0, "R9 virt after reset", lat, 0);

    // R1 / R4 directed
    trig(); capturePair(7);
    checkOfs("R1 capture 7", 7);
    measureVirt(lat);
    check(lat == 7, "R4 virt delay 7", lat, 7);

    // R3: unarmed feedback does nothing
    capturePair(12);
    checkOfs("R3 hold without trigger", 7);
    measureVirt(lat);
    check(lat == 7, "R3 virt delay held", lat, 7);

    // R1 boundaries
    trig(); capturePair(0);
    checkOfs("R1 capture same cycle", 0);
    trig(); capturePair(PERIOD-1);
    checkOfs("R1 capture max", PERIOD-1);
    measureVirt(lat);
    check(lat == PERIOD-1, "R4 virt delay max", lat, PERIOD-1);

    // R2: holdover exit gated by enable
    holdRecoverEn = 1'b0;
    holdover = 1'b1; tick(3); holdover = 1'b0; tick(3);
    capturePair(5);
    checkOfs("R2 no capture when disabled", PERIOD-1);
    holdRecoverEn = 1'b1;
    holdover = 1'b1; tick(3); holdover = 1'b0; tick(3);
    capturePair(5);
    checkOfs("R2 capture on holdover exit", 5);

    // R5 / R6 / R7 downward removal from 15
    trig(); capturePair(15);
    clearPulse(); tick(DIV + 8 - 2);
    checkOfs("R5 first step after clear", slewModel(15, 1));
    tick(2*DIV);
    checkOfs("R6 three steps", slewModel(15, 3));
    tick(12*DIV);
    checkOfs("R5 reaches zero", 0);
    tick(2*DIV);
    checkOfs("R5 stays aligned", 0);
    measureVirt(lat);
    check(lat == 0, "R5 virt aligned", lat, 0);

    // R7 upward removal with wrap from 30
    trig(); capturePair(30);
    clearPulse(); tick(DIV + 8 - 2);
    checkOfs("R7 step up", 31);
    tick(8*DIV);
    checkOfs("R7 nine steps up", PERIOD-1);
    tick(DIV);
    checkOfs("R7 wrap to zero", 0);

    // R7 boundary at half and just above
    trig(); capturePair(PERIOD/2 + 1);
    clearPulse(); tick(DIV + 8 - 2);
    checkOfs("R7 above half increments", PERIOD/2 + 2);
    trig(); capturePair(PERIOD/2);
    checkOfs("R10 capture during slew", PERIOD/2);
    clearPulse(); tick(DIV + 8 - 2);
    checkOfs("R7 half decrements", PERIOD/2 - 1);

    // R10: capture after release ends removal
    trig(); capturePair(9);
    tick(4*DIV);
    checkOfs("R10 offset held after capture", 9);

    // R8: clear held low
    @(negedge clk);
    clrN = 1'b0;
    tick(12*DIV);
    checkOfs("R8 removed while low", 0);
    trig(); capturePair(11);
    checkOfs("R8 capture blocked", 0);
    measureVirt(lat);
    check(lat == 0, "R8 virt equals ref", lat, 0);
    clrN = 1'b1;
    tick(5);
    capturePair(13);
    checkOfs("R8 dropped arm stays dropped", 0);

    // random captures
    for (int i = 0; i < 10; i++) begin
      d = $urandom_range(PERIOD-1, 0);
      trig(); capturePair(d);
      checkOfs("R1 random capture", d);
      measureVirt(lat);
      check(lat == d, "R4 random virt delay", lat, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule